// File: doc/BRIEF.md
# Fast-Lock Acquisition and Tracking Sequencer

This block drives the control word of a digitally tuned multiplying delay-locked loop from the moment the loop is enabled until it holds lock. On enable the 16-bit oscillator control word is loaded with the maximum-frequency setting. The block then runs a series of time-to-digital searches. Each search takes three reference cycles. In the first cycle the converter measures period plus phase error plus its own offset. In the second it measures period plus offset. In the third the two codes are subtracted, which cancels the offset. The signed result, scaled by a programmable gain, is added to the upper ten bits of the word with saturation.

When a search yields a zero difference, meaning the error is below one converter step, the block declares lock. It also declares lock once the fifth search finishes, and in that case it raises a status bit to mark the lock as forced. After lock, the converter enable drops and the tracking enable rises. From then on, each reference cycle's bang-bang decision moves the whole word by one LSB, with saturation at both ends. Deasserting the enable restarts the sequence from the preset.

The converter result path is a valid-only stream. `tdc_done` qualifies `tdc_code` for one cycle. The block has no ready signal and never applies back-pressure, because it can take a code in any cycle. A code is stored only while the matching measurement phase is open, and a later code in the same phase replaces the earlier one. The other pins are plain level or strobe controls sampled on the clock.

Top module: `lockseq_ctrl`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with `en` low, `lf_word` equals the preset 0x0000 (maximum frequency) and `tdc_en`, `track_en`, `locked` and `forced_lock` are 0.
- R2: A search is three `ref_tick` strobes. The first and second strobes each cause a one-cycle `tdc_start` pulse in the following cycle. The first code delivered with `tdc_done` after the first strobe is stored as the error sample, and the code after the second strobe is stored as the reference sample.
- R3: At the third strobe, bits [15:6] of `lf_word` become clamp(bits[15:6] + ((error − reference) × 2^`gain_sel`), 0, 1023), and bits [5:0] are kept unchanged.
- R4: While `en` is high, `lf_word` changes only in the cycle after a `ref_tick` strobe. The first two strobes of a search leave it unchanged.
- R5: If the difference applied at the third strobe is zero, `locked` and `track_en` are 1 and `tdc_en` is 0 from the next cycle, and `forced_lock` stays 0.
- R6: If the fifth search ends with a nonzero difference, the block still locks, and `forced_lock` is 1 together with `locked`.
- R7: In tracking, each `ref_tick` moves `lf_word` by +1 when `bb_up`=1 and by −1 when `bb_up`=0. The word holds at 0xFFFF going up and at 0x0000 going down.
- R8: `tdc_en` is 1 from the cycle after `en` rises until lock, `tdc_en` and `track_en` are never 1 together, and `locked` equals `track_en`.
- R9: Dropping `en` after lock returns the word to the preset and clears the lock flags. Raising it again starts a fresh acquisition with a full budget of five searches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Loop enable; low holds the preset |
| ref_tick | input | 1 | One-cycle strobe per reference cycle |
| gain_sel | input | 2 | Left shift applied to the search difference |
| tdc_start | output | 1 | One-cycle request to start a converter measurement |
| tdc_done | input | 1 | Valid qualifier for `tdc_code` |
| tdc_code | input | 10 | Converter result |
| bb_up | input | 1 | Bang-bang decision, 1 = increase delay |
| lf_word | output | 16 | Oscillator control word |
| tdc_en | output | 1 | Acquisition mode, converter enabled |
| track_en | output | 1 | Tracking mode, phase detector and modulator enabled |
| locked | output | 1 | Lock flag |
| forced_lock | output | 1 | Lock was forced by the search limit |

## Verification
The assertions check in every cycle the rules that hold at each clock edge. They cover the preset after a disabled cycle, the single-cycle start pulse, the preserved low bits during acquisition, the quiet word between strobes, the one-step moves in tracking, and the mutual exclusion of the two mode flags. The bench scenarios are what show the arithmetic of a search. These are the difference, the gain shift and the clamps at both ends of the ten-bit field. The scenarios also show the decision between a natural lock and a forced lock after the fifth search, saturation of the tracking word at 0xFFFF and 0x0000, and the restart after the enable drops.

// File: rtl/lockseq_pkg.sv
package lockseq_pkg;
  typedef enum logic [2:0] {
    PH_OFF   = 3'd0,
    PH_WAIT  = 3'd1,
    PH_MEAS1 = 3'd2,
    PH_MEAS2 = 3'd3,
    PH_TRACK = 3'd4
  } phase_t;
endpackage

// File: rtl/lockseq_fsm.sv
module lockseq_fsm
  import lockseq_pkg::*;
#(
  parameter int MAX_SEARCH = 5
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  logic   ref_tick,
  input  logic   err_zero,
  output phase_t phase,
  output logic   apply,
  output logic   tdc_start,
  output logic   forced
);
  localparam int CNT_W = $clog2(MAX_SEARCH + 1);

  logic [CNT_W-1:0] done_cnt;
  logic             last_search;

  assign last_search = (done_cnt == CNT_W'(MAX_SEARCH - 1));
  assign apply       = en && ref_tick && (phase == PH_MEAS2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_OFF;
      done_cnt  <= '0;
      forced    <= 1'b0;
      tdc_start <= 1'b0;
    end else if (!en) begin
      phase     <= PH_OFF;
      done_cnt  <= '0;
      forced    <= 1'b0;
      tdc_start <= 1'b0;
    end else begin
      tdc_start <= 1'b0;
      case (phase)
        PH_OFF: phase <= PH_WAIT;
        PH_WAIT:
          if (ref_tick) begin
            phase     <= PH_MEAS1;
            tdc_start <= 1'b1;
          end
        PH_MEAS1:
          if (ref_tick) begin
            phase     <= PH_MEAS2;
            tdc_start <= 1'b1;
          end
        PH_MEAS2:
          if (ref_tick) begin
            if (err_zero || last_search) begin
              phase  <= PH_TRACK;
              forced <= !err_zero;
            end else begin
              phase    <= PH_WAIT;
              done_cnt <= done_cnt + 1'b1;
            end
          end
        PH_TRACK: phase <= PH_TRACK;
        default:  phase <= PH_OFF;
      endcase
    end
  end
endmodule

// File: rtl/lockseq_cds.sv
module lockseq_cds
  import lockseq_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  phase_t                   phase,
  input  logic                     tdc_done,
  input  logic [CODE_W-1:0]        tdc_code,
  output logic signed [CODE_W:0]   diff,
  output logic                     err_zero
);
  logic [CODE_W-1:0] err_code;
  logic [CODE_W-1:0] ref_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_code <= '0;
      ref_code <= '0;
    end else if (tdc_done) begin
      if (phase == PH_MEAS1) err_code <= tdc_code;
      if (phase == PH_MEAS2) ref_code <= tdc_code;
    end
  end

  assign diff     = $signed({1'b0, err_code}) - $signed({1'b0, ref_code});
  assign err_zero = (err_code == ref_code);
endmodule

// File: rtl/lockseq_word.sv
module lockseq_word #(
  parameter int              LF_W      = 16,
  parameter int              FIELD_LSB = 6,
  parameter int              DIFF_W    = 11,
  parameter int              GAIN_W    = 2,
  parameter logic [LF_W-1:0] PRESET    = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     apply,
  input  logic signed [DIFF_W-1:0] diff,
  input  logic [GAIN_W-1:0]        gain_sel,
  input  logic                     track_step,
  input  logic                     bb_up,
  output logic [LF_W-1:0]          lf_word
);
  localparam int FIELD_W  = LF_W - FIELD_LSB;
  localparam int SCALED_W = DIFF_W + (2 ** GAIN_W) - 1;
  localparam int SUM_W    = SCALED_W + FIELD_W;

  logic [FIELD_W-1:0]         field;
  logic signed [SCALED_W-1:0] diff_ext;
  logic signed [SCALED_W-1:0] scaled;
  logic [SUM_W-1:0]           sum;
  logic [FIELD_W-1:0]         new_field;
  logic [LF_W-1:0]            step_word;

  assign field    = lf_word[LF_W-1:FIELD_LSB];
  assign diff_ext = {{(SCALED_W - DIFF_W){diff[DIFF_W-1]}}, diff};
  assign scaled   = diff_ext <<< gain_sel;
  assign sum      = {{(SUM_W - FIELD_W){1'b0}}, field}
                  + {{(SUM_W - SCALED_W){scaled[SCALED_W-1]}}, scaled};

  always_comb begin
    if (sum[SUM_W-1])                      new_field = '0;
    else if (|sum[SUM_W-2:FIELD_W])        new_field = '1;
    else                                   new_field = sum[FIELD_W-1:0];
  end

  always_comb begin
    if (bb_up) step_word = (lf_word == '1) ? lf_word : lf_word + 1'b1;
    else       step_word = (lf_word == '0) ? lf_word : lf_word - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lf_word <= PRESET;
    else if (!en)        lf_word <= PRESET;
    else if (apply)      lf_word <= {new_field, lf_word[FIELD_LSB-1:0]};
    else if (track_step) lf_word <= step_word;
  end
endmodule

// File: rtl/lockseq_ctrl.sv
module lockseq_ctrl
  import lockseq_pkg::*;
#(
  parameter int              LF_W       = 16,
  parameter int              FIELD_LSB  = 6,
  parameter int              CODE_W     = 10,
  parameter int              GAIN_W     = 2,
  parameter int              MAX_SEARCH = 5,
  parameter logic [LF_W-1:0] PRESET     = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ref_tick,
  input  logic [GAIN_W-1:0] gain_sel,
  output logic              tdc_start,
  input  logic              tdc_done,
  input  logic [CODE_W-1:0] tdc_code,
  input  logic              bb_up,
  output logic [LF_W-1:0]   lf_word,
  output logic              tdc_en,
  output logic              track_en,
  output logic              locked,
  output logic              forced_lock
);
  localparam int DIFF_W = CODE_W + 1;

  phase_t                   phase;
  logic                     apply;
  logic                     err_zero;
  logic signed [DIFF_W-1:0] diff;
  logic                     track_step;

  lockseq_fsm #(.MAX_SEARCH(MAX_SEARCH)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .ref_tick (ref_tick),
    .err_zero (err_zero),
    .phase    (phase),
    .apply    (apply),
    .tdc_start(tdc_start),
    .forced   (forced_lock)
  );

  lockseq_cds #(.CODE_W(CODE_W)) u_cds (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase   (phase),
    .tdc_done(tdc_done),
    .tdc_code(tdc_code),
    .diff    (diff),
    .err_zero(err_zero)
  );

  assign track_step = en && ref_tick && (phase == PH_TRACK);

  lockseq_word #(
    .LF_W     (LF_W),
    .FIELD_LSB(FIELD_LSB),
    .DIFF_W   (DIFF_W),
    .GAIN_W   (GAIN_W),
    .PRESET   (PRESET)
  ) u_word (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .apply     (apply),
    .diff      (diff),
    .gain_sel  (gain_sel),
    .track_step(track_step),
    .bb_up     (bb_up),
    .lf_word   (lf_word)
  );

  assign tdc_en   = (phase == PH_WAIT) || (phase == PH_MEAS1) || (phase == PH_MEAS2);
  assign track_en = (phase == PH_TRACK);
  assign locked   = track_en;
endmodule

// File: rtl/lockseq_ctrl_chk.sv
module lockseq_ctrl_chk #(
  parameter int              LF_W      = 16,
  parameter int              FIELD_LSB = 6,
  parameter logic [LF_W-1:0] PRESET    = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic            ref_tick,
  input logic            bb_up,
  input logic            tdc_start,
  input logic [LF_W-1:0] lf_word,
  input logic            tdc_en,
  input logic            track_en,
  input logic            locked,
  input logic            forced_lock
);
  a_r1_preset_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (lf_word == PRESET) && !locked && !forced_lock);

  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    tdc_start |=> !tdc_start);

  a_r2_start_in_acq: assert property (@(posedge clk) disable iff (!rst_n)
    tdc_start |-> tdc_en);

  a_r3_low_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tdc_en) |=> (lf_word[FIELD_LSB-1:0] == $past(lf_word[FIELD_LSB-1:0])));

  a_r4_quiet_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ref_tick) |=> $stable(lf_word));

  a_r6_forced_is_locked: assert property (@(posedge clk) disable iff (!rst_n)
    forced_lock |-> locked);

  a_r7_track_up: assert property (@(posedge clk) disable iff (!rst_n)
    (en && track_en && ref_tick && bb_up && (lf_word != '1))
      |=> (lf_word == LF_W'($past(lf_word) + 1'b1)));

  a_r7_track_down: assert property (@(posedge clk) disable iff (!rst_n)
    (en && track_en && ref_tick && !bb_up && (lf_word != '0))
      |=> (lf_word == LF_W'($past(lf_word) - 1'b1)));

  a_r8_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(tdc_en && track_en));
endmodule

bind lockseq_ctrl lockseq_ctrl_chk #(
  .LF_W     (LF_W),
  .FIELD_LSB(FIELD_LSB),
  .PRESET   (PRESET)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .ref_tick   (ref_tick),
  .bb_up      (bb_up),
  .tdc_start  (tdc_start),
  .lf_word    (lf_word),
  .tdc_en     (tdc_en),
  .track_en   (track_en),
  .locked     (locked),
  .forced_lock(forced_lock)
);

// File: tb/sim_lockseq_ctrl.sv
module sim_lockseq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        ref_tick = 1'b0;
  logic [1:0]  gain_sel = 2'd0;
  logic        tdc_start;
  logic        tdc_done = 1'b0;
  logic [9:0]  tdc_code = '0;
  logic        bb_up = 1'b0;
  logic [15:0] lf_word;
  logic        tdc_en, track_en, locked, forced_lock;

  lockseq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .ref_tick(ref_tick), .gain_sel(gain_sel),
    .tdc_start(tdc_start), .tdc_done(tdc_done), .tdc_code(tdc_code), .bb_up(bb_up),
    .lf_word(lf_word), .tdc_en(tdc_en), .track_en(track_en), .locked(locked),
    .forced_lock(forced_lock)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [15:0] lf;
    logic        lk;
    logic        fc;
    logic        te;
    string       tag;
  } exp_t;

  exp_t        sbq[$];
  int          checks = 0;
  int          errors = 0;
  logic [15:0] m_lf = 16'h0000;
  bit          finished = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push(input string tag, input logic lk, input logic fc, input logic te);
    exp_t e;
    e.lf = m_lf; e.lk = lk; e.fc = fc; e.te = te; e.tag = tag;
    sbq.push_back(e);
  endtask

  // monitor: compares one expected item per cycle, 2 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        check(lf_word == e.lf, e.tag, "lf_word", lf_word, e.lf);
        check(locked == e.lk, e.tag, "locked", locked, e.lk);
        check(forced_lock == e.fc, e.tag, "forced_lock", forced_lock, e.fc);
        check(tdc_en == e.te, e.tag, "tdc_en", tdc_en, e.te);
        check(track_en == e.lk, "R8", "track_en", track_en, e.lk);
      end
    end
  end

  task automatic tick();
    @(negedge clk) ref_tick = 1'b1;
    @(negedge clk) ref_tick = 1'b0;
  endtask

  task automatic meas(input logic [9:0] code);
    tick();
    check(tdc_start == 1'b1, "R2", "tdc_start after strobe", tdc_start, 1);
    push("R4", 1'b0, 1'b0, 1'b1);
    tdc_done = 1'b1;
    tdc_code = code;
    @(negedge clk);
    tdc_done = 1'b0;
    check(tdc_start == 1'b0, "R2", "tdc_start pulse width", tdc_start, 0);
  endtask

  task automatic search(input int a, input int b, input int g,
                        input logic lk, input logic fc, input string tag);
    int f;
    gain_sel = 2'(g);
    meas(10'(a));
    meas(10'(b));
    tick();
    f = int'(m_lf[15:6]) + (a - b) * (1 << g);
    if (f < 0) f = 0;
    if (f > 1023) f = 1023;
    m_lf = {10'(f), m_lf[5:0]};
    push(tag, lk, fc, !lk);
  endtask

  task automatic trk(input logic up);
    bb_up = up;
    tick();
    if (up && m_lf != 16'hFFFF) m_lf = m_lf + 16'd1;
    if (!up && m_lf != 16'h0000) m_lf = m_lf - 16'd1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(lf_word == 16'h0000, "R1", "reset lf_word", lf_word, 0);
    check(!tdc_en && !track_en && !locked && !forced_lock, "R1", "reset flags",
          {tdc_en, track_en, locked, forced_lock}, 0);
    rst_n = 1'b1;
    @(negedge clk) en = 1'b1;
    repeat (2) @(negedge clk);
    check(tdc_en == 1'b1, "R8", "tdc_en after enable", tdc_en, 1);
    check(track_en == 1'b0, "R8", "track_en after enable", track_en, 0);

    search(300, 100, 0, 1'b0, 1'b0, "R3");   // field 200
    search(120, 150, 1, 1'b0, 1'b0, "R3");   // field 140
    search(0, 1000, 3, 1'b0, 1'b0, "R3");    // clamp low to 0
    search(1023, 0, 3, 1'b0, 1'b0, "R3");    // clamp high to 1023
    search(10, 20, 0, 1'b1, 1'b1, "R6");     // fifth search, forced

    for (int i = 0; i < 3; i++) begin trk(1'b1); push("R7", 1'b1, 1'b1, 1'b0); end
    for (int i = 0; i < 2; i++) begin trk(1'b0); push("R7", 1'b1, 1'b1, 1'b0); end
    for (int i = 0; i < 800; i++) trk(1'b1);
    push("R7", 1'b1, 1'b1, 1'b0);
    trk(1'b1); push("R7", 1'b1, 1'b1, 1'b0);
    trk(1'b0); push("R7", 1'b1, 1'b1, 1'b0);
    @(negedge clk);

    en = 1'b0;
    @(negedge clk);
    m_lf = 16'h0000;
    check(lf_word == 16'h0000, "R9", "lf_word after disable", lf_word, 0);
    check(!locked && !forced_lock && !tdc_en, "R9", "flags after disable",
          {locked, forced_lock, tdc_en}, 0);
    en = 1'b1;
    repeat (2) @(negedge clk);
    check(tdc_en == 1'b1, "R9", "acquisition restarts", tdc_en, 1);
    search(50, 50, 2, 1'b1, 1'b0, "R5");     // zero difference, natural lock
    trk(1'b0); push("R7", 1'b1, 1'b0, 1'b0); // holds at zero
    trk(1'b1); push("R7", 1'b1, 1'b0, 1'b0);

    while (sbq.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule